// File: doc/BRIEF.md
# Wake Event Status and Enable

This block collects wake requests from a set of asynchronous wake-source inputs and turns them into a sticky pending flag. That flag can drive an active-low power-management event output and an interrupt request. Each source passes through a two-flop synchronizer. A rising edge on any synchronized source sets the pending flag, whatever the enable settings are. A source that stays high does not set the flag again once software has cleared it.

Software reaches the block through a byte-wide register bus. A programmable base address selects two registers. The event status register sits at offset 0x10 from the base. It holds the pending flag in bit 0, which is cleared by writing 1, and the output enable in bit 1. The interrupt enable register sits at offset 0x09 from the base and holds the interrupt enable in bit 0. A battery-backed power-on reset clears all state.

Top module: `wake_evt_block`

## Requirements
- R1: While porRstN is low and after its release, both registers read 0x00, pmeN is 1 and sciReq is 0.
- R2: A rising edge on any bit of wakeIn sets the pending flag (status register bit 0) whatever the values of the output enable and the interrupt enable.
- R3: A wake source that stays high, or that falls, does not set the pending flag again after it has been cleared.
- R4: Writing the status register with data bit 0 = 1 clears the pending flag. Writing it with data bit 0 = 0 leaves the flag unchanged.
- R5: pmeN is 0 exactly when the pending flag is 1 and the output enable (status register bit 1, read/write) is 1. Clearing the flag returns pmeN to 1.
- R6: sciReq is 1 exactly when the pending flag, the output enable and the interrupt enable (interrupt enable register bit 0, read/write) are all 1.
- R7: Reserved bits read as 0: bits 7..2 of the status register and bits 7..1 of the interrupt enable register. Writing 1 to them has no effect.
- R8: If a wake edge reaches the flag in the same clock edge as a write that clears it, the flag stays at 1.
- R9: Only busAddr = baseAddr + 0x09 and baseAddr + 0x10 are decoded, with the sum taken modulo 2^ADDR_W. A write to any other address changes nothing, and a read there returns 0.
- R10: rdData presents the addressed register while rdStrobe is 1, combinationally in that same cycle, and is 0 while rdStrobe is 0.
- R11: When a wakeIn bit rises between two clock edges, the pending flag still reads 0 after the second following clock edge and reads 1 after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porRstN | input | 1 | Battery-backed power-on reset, active low, asynchronous |
| baseAddr | input | ADDR_W | Base address of the register pair |
| busAddr | input | ADDR_W | Bus access address |
| rdStrobe | input | 1 | Read access this cycle |
| wrStrobe | input | 1 | Write access this cycle |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, combinational |
| wakeIn | input | NUM_SRC | Asynchronous wake-source inputs, active high |
| pmeN | output | 1 | Power-management event output, active low |
| sciReq | output | 1 | Interrupt request |

## Verification
The bench builds the block with three wake sources, an 8-bit address and a base of 0xF8. With that base, both register offsets wrap past the top of the address space and land at 0x01 and 0x08. Because the address is 8 bits wide, all 256 addresses can be swept for stray writes and reads. With three sources, the bench can pulse every source under both output-enable settings. It also walks all eight combinations of flag, output enable and interrupt enable, and it lines a wake edge up with a clearing write to the exact clock edge.

// File: rtl/wake_evt_pkg.sv
package wake_evt_pkg;

  typedef struct packed {
    logic stsWr;
    logic enWr;
    logic stsRd;
    logic enRd;
  } regStrobe_t;

  localparam int PEND_BIT   = 0;
  localparam int PME_EN_BIT = 1;
  localparam int SCI_EN_BIT = 0;

endpackage

// File: rtl/wake_evt_sync.sv
module wake_evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic porRstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) chain <= '0;
    else          chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/wake_evt_ctrl.sv
module wake_evt_ctrl
  import wake_evt_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int OFS_EVT_EN = 9,
  parameter int OFS_STS    = 16
) (
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  output regStrobe_t        strb
);

  localparam logic [ADDR_W-1:0] EN_OFS  = ADDR_W'(OFS_EVT_EN);
  localparam logic [ADDR_W-1:0] STS_OFS = ADDR_W'(OFS_STS);

  logic [ADDR_W-1:0] relAddr;
  logic              hitEn;
  logic              hitSts;

  always_comb begin
    relAddr = busAddr - baseAddr;
    hitEn   = (relAddr == EN_OFS);
    hitSts  = (relAddr == STS_OFS);
  end

  always_comb begin
    strb.stsWr = wrStrobe & hitSts;
    strb.enWr  = wrStrobe & hitEn;
    strb.stsRd = rdStrobe & hitSts;
    strb.enRd  = rdStrobe & hitEn;
  end

endmodule

// File: rtl/wake_evt_dp.sv
module wake_evt_dp
  import wake_evt_pkg::*;
#(
  parameter int NUM_SRC     = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               porRstN,
  input  regStrobe_t         strb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] wakeIn,
  output logic [DATA_W-1:0]  rdData,
  output logic               pmeN,
  output logic               sciReq,
  output logic               stsBit,
  output logic               pmeEnBit,
  output logic               sciEnBit,
  output logic               anyEdge
);

  logic [NUM_SRC-1:0] wakeSync;
  logic [NUM_SRC-1:0] wakePrev;
  logic [NUM_SRC-1:0] wakeRise;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    wake_evt_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk     (clk),
      .porRstN (porRstN),
      .asyncIn (wakeIn[s]),
      .syncOut (wakeSync[s])
    );
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) wakePrev <= '0;
    else          wakePrev <= wakeSync;
  end

  always_comb begin
    wakeRise = wakeSync & ~wakePrev;
    anyEdge  = |wakeRise;
  end

  // Pending flag: a new edge has priority over a clearing write.
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)                          stsBit <= 1'b0;
    else if (anyEdge)                      stsBit <= 1'b1;
    else if (strb.stsWr && wrData[PEND_BIT]) stsBit <= 1'b0;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)        pmeEnBit <= 1'b0;
    else if (strb.stsWr) pmeEnBit <= wrData[PME_EN_BIT];
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)       sciEnBit <= 1'b0;
    else if (strb.enWr) sciEnBit <= wrData[SCI_EN_BIT];
  end

  always_comb begin
    pmeN   = ~(stsBit & pmeEnBit);
    sciReq = stsBit & pmeEnBit & sciEnBit;
  end

  always_comb begin
    rdData = '0;
    if (strb.stsRd) begin
      rdData[PEND_BIT]   = stsBit;
      rdData[PME_EN_BIT] = pmeEnBit;
    end else if (strb.enRd) begin
      rdData[SCI_EN_BIT] = sciEnBit;
    end
  end

endmodule

// File: rtl/wake_evt_block.sv
module wake_evt_block
  import wake_evt_pkg::*;
#(
  parameter int NUM_SRC     = 4,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int OFS_EVT_EN  = 9,
  parameter int OFS_STS     = 16
) (
  input  logic               clk,
  input  logic               porRstN,
  input  logic [ADDR_W-1:0]  baseAddr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               rdStrobe,
  input  logic               wrStrobe,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_SRC-1:0] wakeIn,
  output logic               pmeN,
  output logic               sciReq
);

  regStrobe_t strb;
  logic       stsBit;
  logic       pmeEnBit;
  logic       sciEnBit;
  logic       anyEdge;

  wake_evt_ctrl #(
    .ADDR_W     (ADDR_W),
    .OFS_EVT_EN (OFS_EVT_EN),
    .OFS_STS    (OFS_STS)
  ) i_ctrl (
    .baseAddr (baseAddr),
    .busAddr  (busAddr),
    .rdStrobe (rdStrobe),
    .wrStrobe (wrStrobe),
    .strb     (strb)
  );

  wake_evt_dp #(
    .NUM_SRC     (NUM_SRC),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_dp (
    .clk      (clk),
    .porRstN  (porRstN),
    .strb     (strb),
    .wrData   (wrData),
    .wakeIn   (wakeIn),
    .rdData   (rdData),
    .pmeN     (pmeN),
    .sciReq   (sciReq),
    .stsBit   (stsBit),
    .pmeEnBit (pmeEnBit),
    .sciEnBit (sciEnBit),
    .anyEdge  (anyEdge)
  );

endmodule

// File: rtl/wake_evt_chk.sv
module wake_evt_chk
  import wake_evt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              porRstN,
  input logic              rdStrobe,
  input logic [DATA_W-1:0] rdData,
  input logic [DATA_W-1:0] wrData,
  input logic              pmeN,
  input logic              sciReq,
  input regStrobe_t        strb,
  input logic              stsBit,
  input logic              anyEdge
);

  p_set_needs_edge_r2: assert property (@(posedge clk) disable iff (!porRstN)
    $rose(stsBit) |-> $past(anyEdge));

  p_sticky_r4: assert property (@(posedge clk) disable iff (!porRstN)
    (stsBit && !(strb.stsWr && wrData[PEND_BIT])) |=> stsBit);

  p_clear_w1c_r4: assert property (@(posedge clk) disable iff (!porRstN)
    (strb.stsWr && wrData[PEND_BIT] && !anyEdge) |=> !stsBit);

  p_pme_release_r5: assert property (@(posedge clk) disable iff (!porRstN)
    (strb.stsWr && wrData[PEND_BIT] && !anyEdge) |=> pmeN);

  p_sci_implies_pme_r6: assert property (@(posedge clk) disable iff (!porRstN)
    sciReq |-> !pmeN);

  p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!porRstN)
    rdData[DATA_W-1:2] == '0);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!porRstN)
    anyEdge |=> stsBit);

  p_decode_onehot_r9: assert property (@(posedge clk) disable iff (!porRstN)
    $onehot0({strb.stsWr, strb.enWr, strb.stsRd, strb.enRd}) || (rdStrobe && (strb.stsWr || strb.enWr)));

  p_idle_read_zero_r10: assert property (@(posedge clk) disable iff (!porRstN)
    !rdStrobe |-> (rdData == '0));

endmodule

bind wake_evt_block wake_evt_chk #(.DATA_W(DATA_W)) i_chk (
  .clk      (clk),
  .porRstN  (porRstN),
  .rdStrobe (rdStrobe),
  .rdData   (rdData),
  .wrData   (wrData),
  .pmeN     (pmeN),
  .sciReq   (sciReq),
  .strb     (strb),
  .stsBit   (stsBit),
  .anyEdge  (anyEdge)
);

// File: tb/test_wake_evt_block.sv
module test_wake_evt_block;

  localparam int NSRC = 3;
  localparam logic [7:0] BASE   = 8'hF8;
  localparam logic [7:0] EN_AD  = BASE + 8'h09;
  localparam logic [7:0] STS_AD = BASE + 8'h10;

  logic            clk = 1'b0;
  logic            porRstN = 1'b0;
  logic [7:0]      baseAddr = BASE;
  logic [7:0]      busAddr = '0;
  logic            rdStrobe = 1'b0;
  logic            wrStrobe = 1'b0;
  logic [7:0]      wrData = '0;
  logic [7:0]      rdData;
  logic [NSRC-1:0] wakeIn = '0;
  logic            pmeN;
  logic            sciReq;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  wake_evt_block #(.NUM_SRC(NSRC), .ADDR_W(8), .DATA_W(8)) i_wake_evt_block (
    .clk(clk), .porRstN(porRstN), .baseAddr(baseAddr), .busAddr(busAddr),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .wrData(wrData), .rdData(rdData),
    .wakeIn(wakeIn), .pmeN(pmeN), .sciReq(sciReq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; wrData = d; wrStrobe = 1'b1;
    @(posedge clk);
    #1 wrStrobe = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; rdStrobe = 1'b1;
    #1 d = rdData;
    rdStrobe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] rv;

    idle(3);
    check("R1 pmeN in reset", 32'(pmeN), 1);
    check("R1 sciReq in reset", 32'(sciReq), 0);
    @(negedge clk) porRstN = 1'b1;
    busRead(STS_AD, rv); check("R1 status after reset", 32'(rv), 0);
    busRead(EN_AD, rv);  check("R1 enable after reset", 32'(rv), 0);

    // Reserved bits and idle read
    busWrite(EN_AD, 8'hFF);
    busRead(EN_AD, rv);  check("R7 enable reserved", 32'(rv), 32'h01);
    busWrite(STS_AD, 8'hFE);
    busRead(STS_AD, rv); check("R7 status reserved", 32'(rv), 32'h02);
    @(negedge clk) busAddr = STS_AD;
    #1 check("R10 idle rdData", 32'(rdData), 0);
    busWrite(EN_AD, 8'h00);
    busWrite(STS_AD, 8'h00);

    // Each source, both output-enable settings
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < NSRC; s++) begin
        busWrite(STS_AD, 8'((p << 1) | 1));
        @(negedge clk) wakeIn[s] = 1'b1;
        idle(2);
        busRead(STS_AD, rv); check("R11 not yet set", 32'(rv[0]), 0);
        idle(1);
        busRead(STS_AD, rv); check("R2 flag set by edge", 32'(rv[0]), 1);
        check("R5 pmeN with flag", 32'(pmeN), 32'(p == 0));
        busWrite(STS_AD, 8'(p << 1));
        busRead(STS_AD, rv); check("R4 write 0 keeps flag", 32'(rv[0]), 1);
        busWrite(STS_AD, 8'((p << 1) | 1));
        busRead(STS_AD, rv); check("R4 write 1 clears", 32'(rv[0]), 0);
        check("R5 pmeN released", 32'(pmeN), 1);
        idle(5);
        busRead(STS_AD, rv); check("R3 held high no reset", 32'(rv[0]), 0);
        @(negedge clk) wakeIn[s] = 1'b0;
        idle(5);
        busRead(STS_AD, rv); check("R3 falling edge ignored", 32'(rv[0]), 0);
      end
    end

    // All combinations of flag, output enable, interrupt enable
    for (int c = 0; c < 8; c++) begin
      bit f, pe, se;
      f = c[0]; pe = c[1]; se = c[2];
      busWrite(STS_AD, 8'((int'(pe) << 1) | 1));
      busWrite(EN_AD, 8'(se));
      if (f) begin
        @(negedge clk) wakeIn[0] = 1'b1;
        idle(4);
        @(negedge clk) wakeIn[0] = 1'b0;
        idle(4);
      end
      @(negedge clk);
      check("R5 pmeN combo", 32'(pmeN), 32'(!(f && pe)));
      check("R6 sciReq combo", 32'(sciReq), 32'(f && pe && se));
    end
    busWrite(EN_AD, 8'h00);
    busWrite(STS_AD, 8'h01);

    // Set beats clear in the same edge
    @(negedge clk) wakeIn[1] = 1'b1;
    idle(2);
    busWrite(STS_AD, 8'h01);
    busRead(STS_AD, rv); check("R8 set wins", 32'(rv[0]), 1);
    busWrite(STS_AD, 8'h01);
    busRead(STS_AD, rv); check("R8 later clear", 32'(rv[0]), 0);
    @(negedge clk) wakeIn[1] = 1'b0;
    idle(4);

    // Full address sweep with wrapped offsets
    for (int a = 0; a < 256; a++) begin
      if (8'(a) != EN_AD && 8'(a) != STS_AD) begin
        busWrite(8'(a), 8'hFF);
        busRead(8'(a), rv); check("R9 stray read", 32'(rv), 0);
        busRead(EN_AD, rv); check("R9 enable untouched", 32'(rv), 0);
        busRead(STS_AD, rv); check("R9 status untouched", 32'(rv), 0);
      end
    end

    // Relocated base
    @(negedge clk) baseAddr = 8'h00;
    busWrite(8'h09, 8'h01);
    busRead(8'h09, rv); check("R9 new base enable", 32'(rv), 1);
    busRead(EN_AD, rv); check("R9 old address dead", 32'(rv), 0);

    summary();
  end

endmodule